// File: doc/BRIEF.md
# Coherence Snoop Dispatcher

This block runs after a last-level cache miss and decides which caching agents receive a snoop. It applies one of four runtime-selectable policies. In the first, the requester snoops every other agent straight away. In the second, the request goes to a home stage, which then snoops everyone. In the third, the home stage consults a small directory cache first and snoops only the agents that the entry marks. In the fourth, the remote-socket snoop and the memory-directory read start at once and run alongside the directory lookup, so the remote snoop does not wait behind it.

The agents form a bit vector of `N_AGENTS` bits. Bit `N_AGENTS-1` is the remote socket and the lower bits are local agents. Requests always come from a local agent. The directory cache sits outside this block: the dispatcher raises a lookup strobe, and the cache answers with a hit flag and a presence vector in that same cycle. A request completes when every snoop it issued has been answered and any memory-directory read it started has returned.

Top module: `snoop_dispatch`

## Requirements
- R1: After reset `req_ready` is 1, and `snoop_tgt`, `memdir_rd`, `dir_lookup` and `done` are 0. The policy register holds 3 (opportunistic), so a request made before any configuration write follows R6.
- R2: `cfg_mode` is written into the policy register when `cfg_we` is high. The encodings are 0 broadcast, 1 home, 2 directory and 3 opportunistic. The policy is captured when a request is accepted, so a write made during a request applies only from the next request.
- R3: Broadcast (0). In the first cycle after acceptance, `snoop_tgt` holds every agent except the requester. No memory-directory read is issued.
- R4: Home (1). The first cycle after acceptance issues nothing. In the second cycle, `snoop_tgt` holds every agent except the requester and `memdir_rd` pulses.
- R5: Directory (2). `dir_lookup` is high in the second cycle after acceptance. In the third cycle, `snoop_tgt` holds `dir_vec` on a hit, or every agent on a miss, in both cases without the requester, and `memdir_rd` pulses.
- R6: Opportunistic (3). In the second cycle after acceptance, `snoop_tgt` holds only the remote bit (`N_AGENTS-1`), and `memdir_rd` and `dir_lookup` are high. In the third cycle, `snoop_tgt` holds the local agents chosen as in R5, without the requester and without the remote bit.
- R7: The requester is never snooped, and no agent is snooped twice within one request. `snoop_tgt` is nonzero only in issue cycles, and a zero vector means no snoop.
- R8: Take the clock edge that captures the last outstanding `snp_rsp` bit or `memdir_done`. `done` is high for exactly one cycle after the edge that follows it, and `req_ready` returns to 1 in that same cycle.
- R9: A `snp_rsp` bit for an agent with no outstanding snoop has no effect. `memdir_done` with no read outstanding has no effect.
- R10: `req_valid` is ignored while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Policy register write enable |
| cfg_mode | input | 2 | Policy to write (0 broadcast, 1 home, 2 directory, 3 opportunistic) |
| req_valid | input | 1 | Miss request present |
| req_src | input | $clog2(N_AGENTS) | Index of the requesting local agent |
| req_ready | output | 1 | Dispatcher idle, so a request is accepted |
| dir_lookup | output | 1 | Directory cache lookup strobe |
| dir_hit | input | 1 | Directory cache hit, valid while `dir_lookup` is high |
| dir_vec | input | N_AGENTS | Presence vector from the directory entry |
| snoop_tgt | output | N_AGENTS | One-cycle snoop issue vector |
| snp_rsp | input | N_AGENTS | Per-agent snoop response pulses |
| memdir_rd | output | 1 | Memory-directory read strobe |
| memdir_done | input | 1 | Memory-directory read returned |
| done | output | 1 | Request complete pulse |

## Verification
The assertions assume the following about the inputs:
- `req_src` always names a local agent, never the remote bit.
- `dir_hit` and `dir_vec` are stable while `dir_lookup` is high.
- Responses arrive only as single-cycle pulses.

The stimulus follows these rules. The requester index sweeps only the local agents. The directory result is set before each request and held until it completes. Responses are driven as one-cycle pulses after all issue cycles are over. Some of those pulses are deliberately aimed at agents with nothing outstanding. `req_valid` is held high during busy cycles only with a different local source.

// File: rtl/snoop_dispatch.sv
`timescale 1ns/1ps
module snoop_dispatch #(
  parameter int N_AGENTS = 4,
  localparam int SW = $clog2(N_AGENTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_mode,
  input  logic                req_valid,
  input  logic [SW-1:0]       req_src,
  output logic                req_ready,
  output logic                dir_lookup,
  input  logic                dir_hit,
  input  logic [N_AGENTS-1:0] dir_vec,
  output logic [N_AGENTS-1:0] snoop_tgt,
  input  logic [N_AGENTS-1:0] snp_rsp,
  output logic                memdir_rd,
  input  logic                memdir_done,
  output logic                done
);
  typedef enum logic [1:0] {S_IDLE, S_FWD, S_LOOK, S_WAIT} st_t;

  localparam logic [N_AGENTS-1:0] ALL = '1;
  localparam logic [N_AGENTS-1:0] RMT = {1'b1, {(N_AGENTS-1){1'b0}}};

  st_t st, nxt;
  logic [1:0] mode_r, cmode;
  logic [SW-1:0] src_r;
  logic [N_AGENTS-1:0] pend, issue_tgt, src_oh, filt;
  logic mpend, issue_mem;

  assign req_ready  = (st == S_IDLE);
  assign dir_lookup = (st == S_LOOK);
  assign src_oh     = N_AGENTS'(1) << src_r;
  assign filt       = dir_hit ? dir_vec : ALL;

  always_comb begin
    nxt = st;
    issue_tgt = '0;
    issue_mem = 1'b0;
    case (st)
      S_IDLE: if (req_valid) begin
        if (mode_r == 2'd0) begin
          nxt = S_WAIT;
          issue_tgt = ALL & ~(N_AGENTS'(1) << req_src);
        end else begin
          nxt = S_FWD;
        end
      end
      S_FWD: begin
        if (cmode == 2'd1) begin
          issue_tgt = ALL & ~src_oh;
          issue_mem = 1'b1;
          nxt = S_WAIT;
        end else if (cmode == 2'd3) begin
          issue_tgt = RMT & ~src_oh;
          issue_mem = 1'b1;
          nxt = S_LOOK;
        end else begin
          nxt = S_LOOK;
        end
      end
      S_LOOK: begin
        issue_tgt = filt & ~src_oh & ((cmode == 2'd3) ? ~RMT : ALL);
        issue_mem = (cmode == 2'd2);
        nxt = S_WAIT;
      end
      default: if (pend == '0 && !mpend) nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode_r <= 2'd3;
      cmode <= 2'd0;
      src_r <= '0;
      pend <= '0;
      mpend <= 1'b0;
      snoop_tgt <= '0;
      memdir_rd <= 1'b0;
      done <= 1'b0;
    end else begin
      if (cfg_we) mode_r <= cfg_mode;
      if (st == S_IDLE && req_valid) begin
        cmode <= mode_r;
        src_r <= req_src;
      end
      st <= nxt;
      snoop_tgt <= issue_tgt;
      memdir_rd <= issue_mem;
      pend <= (pend & ~snp_rsp) | issue_tgt;
      mpend <= (mpend & ~memdir_done) | issue_mem;
      done <= (st == S_WAIT) && (pend == '0) && !mpend;
    end
  end

  // R7
  no_self_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_tgt & src_oh) == '0);
  // R7
  no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_tgt & pend) == '0);
  // R8
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pend == '0 && !mpend && req_ready));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  bcast_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memdir_rd |-> (cmode != 2'd0));
  // R5
  lookup_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_lookup |-> cmode[1]);
endmodule

// File: tb/snoop_dispatch_test.sv
`timescale 1ns/1ps
module snoop_dispatch_test;
  localparam int N = 4;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_we, req_valid, req_ready, dir_lookup, dir_hit, memdir_rd, memdir_done, done;
  logic [1:0] cfg_mode, req_src;
  logic [N-1:0] dir_vec, snoop_tgt, snp_rsp;
  int total = 0, bad = 0;

  snoop_dispatch #(.N_AGENTS(N)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .req_valid(req_valid), .req_src(req_src), .req_ready(req_ready),
    .dir_lookup(dir_lookup), .dir_hit(dir_hit), .dir_vec(dir_vec),
    .snoop_tgt(snoop_tgt), .snp_rsp(snp_rsp), .memdir_rd(memdir_rd),
    .memdir_done(memdir_done), .done(done));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setmode(int m);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = 2'(m);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run(int m, int s, bit h, logic [3:0] v, bit garbage, bit midcfg, string tag);
    logic [3:0] sb, full, e [3];
    bit mm [3], lk [3];
    logic [3:0] un;
    sb = 4'(1 << s);
    full = 4'hF & ~sb;
    for (int k = 0; k < 3; k++) begin e[k] = 4'h0; mm[k] = 1'b0; lk[k] = 1'b0; end
    case (m)
      0: e[0] = full;
      1: begin e[1] = full; mm[1] = 1'b1; end
      2: begin lk[1] = 1'b1; e[2] = (h ? v : 4'hF) & ~sb; mm[2] = 1'b1; end
      default: begin
        e[1] = 4'h8 & ~sb; mm[1] = 1'b1; lk[1] = 1'b1;
        e[2] = (h ? v : 4'hF) & ~sb & 4'h7;
      end
    endcase
    dir_hit = h; dir_vec = v;
    @(negedge clk); req_valid = 1'b1; req_src = 2'(s);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = garbage; req_src = 2'((s + 1) % 3);
        if (midcfg) begin cfg_we = 1'b1; cfg_mode = 2'd0; end
      end else begin
        cfg_we = 1'b0;
      end
      chk({tag, " snoop_tgt"}, int'(snoop_tgt), int'(e[k]));
      chk({tag, " memdir_rd"}, int'(memdir_rd), int'(mm[k]));
      chk({tag, " dir_lookup"}, int'(dir_lookup), int'(lk[k]));
      chk("R7 requester not snooped", int'(snoop_tgt & sb), 0);
      chk("R10 busy ready low", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    un = e[0] | e[1] | e[2];
    // R9: stray responses plus the memory return
    snp_rsp = ~un; memdir_done = 1'b1;
    @(negedge clk); snp_rsp = '0; memdir_done = 1'b0;
    @(negedge clk);
    chk("R9 stray responses ignored", int'(done), int'(un == 4'h0));
    if (un != 4'h0) begin
      snp_rsp = un;
      @(negedge clk); snp_rsp = '0;
      @(negedge clk);
      chk("R8 done after last response", int'(done), 1);
    end
    chk("R8 ready with done", int'(req_ready), 1);
    @(negedge clk);
    chk("R8 done single pulse", int'(done), 0);
    chk("R10 no extra request accepted", int'(snoop_tgt), 0);
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = '0; req_valid = 1'b0; req_src = '0;
    dir_hit = 1'b0; dir_vec = '0; snp_rsp = '0; memdir_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset snoop_tgt", int'(snoop_tgt), 0);
    chk("R1 reset memdir_rd", int'(memdir_rd), 0);
    chk("R1 reset dir_lookup", int'(dir_lookup), 0);
    chk("R1 reset done", int'(done), 0);
    run(3, 1, 1'b1, 4'b1010, 1'b0, 1'b0, "R1 default opportunistic");
    for (int m = 0; m < 4; m++) begin
      setmode(m);
      for (int s = 0; s < 3; s++)
        for (int h = 0; h < 2; h++)
          for (int v = 0; v < 16; v++) begin
            if (m < 2 && (h != 0 || v != 0)) continue;
            run(m, s, h[0], 4'(v), v[0] | (m < 2 ? s[0] : 1'b0), 1'b0,
                m == 0 ? "R3" : m == 1 ? "R4" : m == 2 ? "R5" : "R6");
          end
    end
    setmode(2);
    run(2, 0, 1'b0, 4'h0, 1'b0, 1'b1, "R2 policy held during request");
    run(0, 2, 1'b0, 4'h0, 1'b0, 1'b0, "R2 new policy next request");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule